// File: doc/BRIEF.md
# Single-Precision Pack and Round Unit

This unit turns an unpacked floating-point value into a packed IEEE 754 single-precision word. The input is a sign, a two-bit class (zero, number, infinity, NaN), a signed unbiased exponent and a 64-bit normalized mantissa with an extra sticky bit from earlier arithmetic. Alongside the word it reports inexact, underflow and overflow flags. It sits at the tail of a floating-point datapath, after the arithmetic that produced the unpacked value.

The datapath is combinational. One of seven result paths is selected:

- PK_ZERO, PK_INF and PK_NAN for the special classes.
- PK_NORMAL for an in-range number.
- PK_SUBNORM for a denormalized result.
- PK_SUB_CARRY for a denormalized result that rounds up into the smallest normal.
- PK_OVERFLOW for a result whose exponent leaves the range.

Path selection is a pure function of the current inputs, so there are no transitions between paths. With the default OUT_REG=1, the word and flags go through one output register that resets to zero.

Rounding follows one of four directions, chosen by a mode input. Overflow saturates either to infinity or to the largest finite value, depending on that direction and on the sign.

Top module: `sp_pack_round`

## Requirements
- R1: When in_class=0 (zero), out_word is the sign in bit 31 with all other bits 0, and all three flags are clear.
- R2: When in_class=2 (infinity), out_word is {sign, 8'hFF, 23'h0}, and all flags are clear.
- R3: When in_class=3 (NaN), out_word is {sign, 8'hFF, in_mant[62:40]} with fraction bit 22 forced to 1. No rounding is applied and no flags are raised.
- R4: Mode 0 rounds to nearest-even. It increments the kept 24-bit significand only when the guard bit is 1 and at least one of these holds: the round bit is 1, sticky is 1, or the kept LSB is 1.
- R5: Modes 1, 2 and 3 use this encoding:
  - Mode 1 (toward zero) never increments.
  - Mode 2 (toward plus infinity) increments only positive values.
  - Mode 3 (toward minus infinity) increments only negative values.
  - No mode increments when guard, round and sticky are all 0.
- R6: flag_inexact is set for any number-class result whose guard, round or sticky bit is nonzero. Sticky is the OR of in_sticky and all mantissa bits below the round bit.
- R7: For a normal number (in_exp+127 >= 1), bit 63 of in_mant is the hidden one and bits 62:40 are the fraction. Bit 39 is the guard bit and bit 38 is the round bit. The exponent field is in_exp+127.
- R8: When rounding a normal value carries out to 2.0, the exponent field grows by one and the fraction becomes 0.
- R9: When in_exp+127 <= 0, the mantissa is shifted right by 1-(in_exp+127) before rounding, and the exponent field is 0. flag_underflow is set if the result is inexact or uf_trap_en is 1.
- R10: A subnormal that rounds up to 1.0x2^-126 gives {sign, 8'h01, 23'h0}, with flag_inexact set and flag_underflow clear.
- R11: If the final biased exponent is 255 or more, flag_overflow and flag_inexact are set. The word is infinity for mode 0, for mode 2 with a positive value and for mode 3 with a negative value. Otherwise the word is {sign, 8'hFE, 23'h7FFFFF}.
- R12: Outputs are registered and appear on the clock edge after the inputs. While rst_n is low, the word and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_sign | input | 1 | Sign of the unpacked value |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Normalized mantissa, leading one at the top bit |
| in_sticky | input | 1 | Sticky bit from earlier arithmetic |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| uf_trap_en | input | 1 | Underflow trap enable |
| out_word | output | 32 | Packed single-precision word |
| flag_inexact | output | 1 | Result was rounded |
| flag_underflow | output | 1 | Tiny result that was inexact or trapped |
| flag_overflow | output | 1 | Result exceeded the finite range |

## Verification
The hardest case to reach is a denormalized result that sits exactly one rounding step below the smallest normal and then carries into it. This needs an exponent of -127 or near it, a mantissa of all ones down to the guard bit, and a mode that increments for that sign. Exact ties and exact subnormals are also rare when the mantissa is random.

The stimulus steers random exponents into bands around the subnormal and overflow boundaries. It clears random runs of low mantissa bits to create exact and tie cases. It also adds directed vectors at exponent -127 with an all-ones mantissa, and at 127 with a carry into overflow.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } num_class_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rnd_mode_e;

    typedef enum logic [2:0] {
        PK_ZERO,
        PK_INF,
        PK_NAN,
        PK_NORMAL,
        PK_SUBNORM,
        PK_SUB_CARRY,
        PK_OVERFLOW
    } pack_path_e;

    localparam int SP_FRAC_W   = 23;
    localparam int SP_EXP_W    = 8;
    localparam int SP_BIAS     = 127;
    localparam int SP_EXP_ALL1 = 255;

endpackage

// File: rtl/sp_denorm_align.sv
module sp_denorm_align #(
    parameter int MANT_W = 64,
    parameter int KEEP_W = 24,
    parameter int SH_W   = 7
) (
    input  logic [MANT_W-1:0] mant_i,
    input  logic [SH_W-1:0]   shift_i,
    output logic [KEEP_W-1:0] keep_o,
    output logic              guard_o,
    output logic              round_o,
    output logic              sticky_o
);
    localparam int LOW_W = MANT_W - KEEP_W;

    logic              full_shift;
    logic [MANT_W-1:0] shifted;
    logic [MANT_W-1:0] lost_mask;
    logic              lost_any;

    always_comb begin
        full_shift = (shift_i >= SH_W'(MANT_W));
        shifted    = full_shift ? '0 : (mant_i >> shift_i);
        lost_mask  = full_shift ? '1 : ((MANT_W'(1) << shift_i) - MANT_W'(1));
        lost_any   = |(mant_i & lost_mask);
        keep_o     = shifted[MANT_W-1 -: KEEP_W];
        guard_o    = shifted[LOW_W-1];
        round_o    = shifted[LOW_W-2];
        sticky_o   = lost_any | (|shifted[LOW_W-3:0]);
    end

endmodule

// File: rtl/sp_round_decide.sv
module sp_round_decide
    import sp_pack_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       sign_i,
    input  logic       lsb_i,
    input  logic       guard_i,
    input  logic       round_i,
    input  logic       sticky_i,
    output logic       incr_o,
    output logic       inexact_o
);
    logic any_lost;

    always_comb begin
        any_lost  = guard_i | round_i | sticky_i;
        inexact_o = any_lost;
        unique case (rnd_mode_e'(mode_i))
            RM_NEAR: incr_o = guard_i & (round_i | sticky_i | lsb_i);
            RM_ZERO: incr_o = 1'b0;
            RM_UP:   incr_o = any_lost & ~sign_i;
            RM_DOWN: incr_o = any_lost & sign_i;
            default: incr_o = 1'b0;
        endcase
    end

    // An increment is only legal when something below the kept LSB is lost
    always_comb begin
        if (incr_o) begin
            assert_inc_needs_grs_R5: assert (guard_i | round_i | sticky_i);
        end
    end

endmodule

// File: rtl/sp_pack_round.sv
module sp_pack_round
    import sp_pack_pkg::*;
#(
    parameter int EXP_W   = 12,
    parameter int MANT_W  = 64,
    parameter int OUT_REG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sign,
    input  logic [1:0]        in_class,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic              in_sticky,
    input  logic [1:0]        rnd_mode,
    input  logic              uf_trap_en,
    output logic [31:0]       out_word,
    output logic              flag_inexact,
    output logic              flag_underflow,
    output logic              flag_overflow
);
    localparam int KEEP_W    = SP_FRAC_W + 1;
    localparam int SH_W      = $clog2(MANT_W) + 1;
    localparam int BEXP_W    = EXP_W + 2;
    localparam int NAN_TOP   = MANT_W - 2;

    // exponent handling
    logic signed [BEXP_W-1:0] bexp;
    logic signed [BEXP_W-1:0] shift_amt;
    logic signed [BEXP_W-1:0] exp_fin;
    logic                     is_sub;
    logic [SH_W-1:0]          shift_sel;

    // aligned significand and rounding
    logic [KEEP_W-1:0]        keep;
    logic                     grd, rnd, stk_low;
    logic                     incr, inexact;
    logic [KEEP_W:0]          rsum;
    logic                     ovf_hit;
    logic                     to_inf;

    pack_path_e               path;

    logic [31:0]              word_c;
    logic                     nx_c, uf_c, of_c;

    always_comb begin
        bexp      = $signed({{2{in_exp[EXP_W-1]}}, in_exp}) + $signed(BEXP_W'(SP_BIAS));
        is_sub    = (bexp <= $signed(BEXP_W'(0)));
        shift_amt = $signed(BEXP_W'(1)) - bexp;
        if (!is_sub)
            shift_sel = '0;
        else if (shift_amt >= $signed(BEXP_W'(MANT_W)))
            shift_sel = SH_W'(MANT_W);
        else
            shift_sel = shift_amt[SH_W-1:0];
    end

    sp_denorm_align #(
        .MANT_W (MANT_W),
        .KEEP_W (KEEP_W),
        .SH_W   (SH_W)
    ) u_align (
        .mant_i   (in_mant),
        .shift_i  (shift_sel),
        .keep_o   (keep),
        .guard_o  (grd),
        .round_o  (rnd),
        .sticky_o (stk_low)
    );

    sp_round_decide u_round (
        .mode_i    (rnd_mode),
        .sign_i    (in_sign),
        .lsb_i     (keep[0]),
        .guard_i   (grd),
        .round_i   (rnd),
        .sticky_i  (stk_low | in_sticky),
        .incr_o    (incr),
        .inexact_o (inexact)
    );

    always_comb begin
        rsum    = {1'b0, keep} + (KEEP_W+1)'(incr);
        exp_fin = bexp + (rsum[KEEP_W] ? $signed(BEXP_W'(1)) : $signed(BEXP_W'(0)));
        ovf_hit = !is_sub && (exp_fin >= $signed(BEXP_W'(SP_EXP_ALL1)));
        unique case (rnd_mode_e'(rnd_mode))
            RM_NEAR: to_inf = 1'b1;
            RM_ZERO: to_inf = 1'b0;
            RM_UP:   to_inf = ~in_sign;
            RM_DOWN: to_inf = in_sign;
            default: to_inf = 1'b1;
        endcase
    end

    // path selection
    always_comb begin
        unique case (num_class_e'(in_class))
            CLS_ZERO: path = PK_ZERO;
            CLS_INF:  path = PK_INF;
            CLS_NAN:  path = PK_NAN;
            CLS_NUM: begin
                if (is_sub)
                    path = rsum[KEEP_W-1] ? PK_SUB_CARRY : PK_SUBNORM;
                else if (ovf_hit)
                    path = PK_OVERFLOW;
                else
                    path = PK_NORMAL;
            end
            default:  path = PK_ZERO;
        endcase
    end

    // output composition per path
    always_comb begin
        word_c = {in_sign, 31'h0};
        nx_c   = 1'b0;
        uf_c   = 1'b0;
        of_c   = 1'b0;
        unique case (path)
            PK_ZERO: begin
                word_c = {in_sign, 31'h0};
            end
            PK_INF: begin
                word_c = {in_sign, 8'hFF, 23'h0};
            end
            PK_NAN: begin
                word_c = {in_sign, 8'hFF,
                          in_mant[NAN_TOP -: SP_FRAC_W] | (SP_FRAC_W'(1) << (SP_FRAC_W-1))};
            end
            PK_NORMAL: begin
                word_c = {in_sign, exp_fin[SP_EXP_W-1:0], rsum[SP_FRAC_W-1:0]};
                nx_c   = inexact;
            end
            PK_SUBNORM: begin
                word_c = {in_sign, 8'h00, rsum[SP_FRAC_W-1:0]};
                nx_c   = inexact;
                uf_c   = inexact | uf_trap_en;
            end
            PK_SUB_CARRY: begin
                word_c = {in_sign, 8'h01, 23'h0};
                nx_c   = 1'b1;
            end
            PK_OVERFLOW: begin
                word_c = to_inf ? {in_sign, 8'hFF, 23'h0}
                                : {in_sign, 8'hFE, 23'h7FFFFF};
                nx_c   = 1'b1;
                of_c   = 1'b1;
            end
            default: begin
                word_c = {in_sign, 31'h0};
            end
        endcase
    end

    generate
        if (OUT_REG != 0) begin : g_out_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_word       <= '0;
                    flag_inexact   <= 1'b0;
                    flag_underflow <= 1'b0;
                    flag_overflow  <= 1'b0;
                end else begin
                    out_word       <= word_c;
                    flag_inexact   <= nx_c;
                    flag_underflow <= uf_c;
                    flag_overflow  <= of_c;
                end
            end

            assert_special_no_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_class != 2'd1) |=> !(flag_inexact || flag_underflow || flag_overflow));

            assert_sub_carry_min_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (path == PK_SUB_CARRY) |=> (out_word[30:0] == 31'h00800000 && !flag_underflow && flag_inexact));
        end else begin : g_out_comb
            always_comb begin
                out_word       = word_c;
                flag_inexact   = nx_c;
                flag_underflow = uf_c;
                flag_overflow  = of_c;
            end
        end
    endgenerate

    assert_no_overflow_without_inexact_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |-> (flag_inexact && out_word[30:24] == 7'h7F));

    assert_underflow_zero_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underflow |-> (out_word[30:23] == 8'h00 && !flag_overflow));

    assert_nan_quiet_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_word[30:23] == 8'hFF && out_word[22:0] != 23'h0) |-> out_word[22]);

endmodule

// File: tb/test_sp_pack_round.sv
`timescale 1ns/1ps
module test_sp_pack_round;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_sign = 1'b0;
    logic [1:0]  in_class = 2'd0;
    logic [11:0] in_exp = '0;
    logic [63:0] in_mant = '0;
    logic        in_sticky = 1'b0;
    logic [1:0]  rnd_mode = 2'd0;
    logic        uf_trap_en = 1'b0;
    logic [31:0] out_word;
    logic        flag_inexact, flag_underflow, flag_overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sp_pack_round i_sp_pack_round (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_sign        (in_sign),
        .in_class       (in_class),
        .in_exp         (in_exp),
        .in_mant        (in_mant),
        .in_sticky      (in_sticky),
        .rnd_mode       (rnd_mode),
        .uf_trap_en     (uf_trap_en),
        .out_word       (out_word),
        .flag_inexact   (flag_inexact),
        .flag_underflow (flag_underflow),
        .flag_overflow  (flag_overflow)
    );

    // Reference: {word, inexact, underflow, overflow}
    function automatic logic [34:0] ref_pack(input logic s, input logic [1:0] c, input int e,
                                              input logic [63:0] m, input logic st,
                                              input logic [1:0] md, input logic tr);
        int           be, sh, fe;
        logic [127:0] ext;
        logic [23:0]  kept;
        logic [103:0] rem, half;
        logic [24:0]  sum;
        logic         any, up, inf;
        if (c == 2'd0) return {s, 31'h0, 3'b000};
        if (c == 2'd2) return {s, 8'hFF, 23'h0, 3'b000};
        if (c == 2'd3) return {s, 8'hFF, 1'b1, m[61:40], 3'b000};
        be = e + 127;
        sh = (be <= 0) ? 1 - be : 0;
        if (sh > 100) sh = 100;
        ext  = {m, 64'h0} >> sh;
        kept = ext[127:104];
        rem  = ext[103:0];
        half = 104'd1 << 103;
        any  = (rem != 0) || st;
        case (md)
            2'd0:    up = (rem > half) || (rem == half && (st || kept[0]));
            2'd1:    up = 1'b0;
            2'd2:    up = any && !s;
            default: up = any && s;
        endcase
        sum = {1'b0, kept} + 25'(up);
        if (be <= 0) begin
            if (sum[23]) return {s, 8'h01, 23'h0, 3'b100};
            return {s, 8'h00, sum[22:0], any, any || tr, 1'b0};
        end
        fe = be + (sum[24] ? 1 : 0);
        if (fe >= 255) begin
            inf = (md == 2'd0) ? 1'b1 : (md == 2'd1) ? 1'b0 : (md == 2'd2) ? !s : s;
            if (inf) return {s, 8'hFF, 23'h0, 3'b101};
            return {s, 8'hFE, 23'h7FFFFF, 3'b101};
        end
        return {s, fe[7:0], sum[22:0], any, 2'b00};
    endfunction

    task automatic apply_chk(input logic s, input logic [1:0] c, input int e, input logic [63:0] m,
                             input logic st, input logic [1:0] md, input logic tr, input string tag);
        logic [34:0] expv, act;
        @(negedge clk);
        in_sign = s; in_class = c; in_exp = e[11:0]; in_mant = m;
        in_sticky = st; rnd_mode = md; uf_trap_en = tr;
        @(negedge clk);
        expv = ref_pack(s, c, e, m, st, md, tr);
        act  = {out_word, flag_inexact, flag_underflow, flag_overflow};
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic known_chk(input logic [31:0] w, input logic [2:0] f, input string tag);
        logic [34:0] act;
        act = {out_word, flag_inexact, flag_underflow, flag_overflow};
        checks++;
        if (act !== {w, f}) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, {w, f});
        end
    endtask

    function automatic string rtag(input logic [1:0] c, input int e, input logic [34:0] r,
                                   input logic [1:0] md);
        if (c == 2'd0) return "R1";
        if (c == 2'd2) return "R2";
        if (c == 2'd3) return "R3";
        if (r[0]) return "R11";
        if (e + 127 <= 0) return (r[33:26] == 8'h01) ? "R10" : "R9";
        if (r[2]) return (md == 2'd0) ? "R4" : "R5";
        return "R7";
    endfunction

    initial begin
        int          e, pick;
        logic [1:0]  c, md;
        logic [63:0] m;
        logic        s, st, tr;
        void'($urandom(32'd20240611));
        // R12: reset state
        @(negedge clk);
        known_chk(32'h0, 3'b000, "R12 reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        apply_chk(1, 2'd0, 0, 64'h0, 0, 2'd0, 0, "R1 neg zero");
        known_chk(32'h80000000, 3'b000, "R1 neg zero word");
        apply_chk(0, 2'd2, 0, 64'h0, 0, 2'd1, 0, "R2 pos inf");
        known_chk(32'h7F800000, 3'b000, "R2 pos inf word");
        apply_chk(0, 2'd3, 0, 64'h8000_0100_0000_0000, 0, 2'd0, 0, "R3 nan payload");
        known_chk(32'h7FC00001, 3'b000, "R3 nan quiet");
        apply_chk(0, 2'd1, 0, 64'h8000_0000_0000_0000, 0, 2'd0, 0, "R7 one");
        known_chk(32'h3F800000, 3'b000, "R7 one word");
        apply_chk(0, 2'd1, 0, 64'h8000_0080_0000_0000, 0, 2'd0, 0, "R4 tie even");
        known_chk(32'h3F800000, 3'b100, "R4 tie even word");
        apply_chk(0, 2'd1, 0, 64'h8000_0180_0000_0000, 0, 2'd0, 0, "R4 tie odd");
        known_chk(32'h3F800002, 3'b100, "R4 tie odd word");
        apply_chk(0, 2'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'd1, 0, "R5 toward zero");
        known_chk(32'h3FFFFFFF, 3'b100, "R5 toward zero word");
        apply_chk(0, 2'd1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'd0, 0, "R8 carry");
        known_chk(32'h40000000, 3'b100, "R8 carry word");
        apply_chk(1, 2'd1, 0, 64'h8000_0000_0000_0001, 0, 2'd2, 0, "R5 plus on negative");
        apply_chk(1, 2'd1, 0, 64'h8000_0000_0000_0001, 0, 2'd3, 0, "R5 minus on negative");
        apply_chk(0, 2'd1, 0, 64'h8000_0000_0000_0000, 1, 2'd2, 0, "R6 sticky input");
        known_chk(32'h3F800001, 3'b100, "R6 sticky input word");
        apply_chk(0, 2'd1, 128, 64'h8000_0000_0000_0000, 0, 2'd0, 0, "R11 nearest");
        known_chk(32'h7F800000, 3'b101, "R11 nearest word");
        apply_chk(0, 2'd1, 128, 64'h8000_0000_0000_0000, 0, 2'd1, 0, "R11 toward zero");
        known_chk(32'h7F7FFFFF, 3'b101, "R11 max finite");
        apply_chk(1, 2'd1, 128, 64'h8000_0000_0000_0000, 0, 2'd2, 0, "R11 plus neg");
        apply_chk(1, 2'd1, 128, 64'h8000_0000_0000_0000, 0, 2'd3, 0, "R11 minus neg");
        apply_chk(0, 2'd1, 127, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'd0, 0, "R11 carry overflow");
        apply_chk(0, 2'd1, -127, 64'h8000_0000_0000_0000, 0, 2'd0, 0, "R9 exact sub");
        known_chk(32'h00400000, 3'b000, "R9 exact sub word");
        apply_chk(0, 2'd1, -127, 64'h8000_0000_0000_0000, 0, 2'd0, 1, "R9 trap enabled");
        known_chk(32'h00400000, 3'b010, "R9 trap word");
        apply_chk(0, 2'd1, -127, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'd0, 1, "R10 carry to normal");
        known_chk(32'h00800000, 3'b100, "R10 min normal word");
        apply_chk(0, 2'd1, -200, 64'h8000_0000_0000_0000, 0, 2'd2, 0, "R9 tiny up");
        known_chk(32'h00000001, 3'b110, "R9 tiny up word");

        for (int i = 0; i < 4000; i++) begin
            pick = $urandom % 16;
            c  = (pick == 0) ? 2'd0 : (pick == 1) ? 2'd2 : (pick == 2) ? 2'd3 : 2'd1;
            case ($urandom % 4)
                0:       e = -160 + int'($urandom % 40);
                1:       e = 100 + int'($urandom % 40);
                2:       e = int'($urandom % 300) - 150;
                default: e = -2048 + int'($urandom % 4096);
            endcase
            m = {1'b1, $urandom, $urandom};
            m[63] = 1'b1;
            if ($urandom % 3 == 0) m = m & ~((64'd1 << ($urandom % 45)) - 64'd1);
            s  = 1'($urandom);
            st = ($urandom % 5 == 0);
            md = 2'($urandom);
            tr = 1'($urandom);
            apply_chk(s, c, e, m, st, md, tr, rtag(c, e, ref_pack(s, c, e, m, st, md, tr), md));
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule